// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block combines a primary and a secondary byte-programmed interrupt controller. Together they serve sixteen request lines, and software sees two separate register pairs. Each controller has a command address and a data address. Writes to these addresses run an initialization sequence, load the mask, select which register a read returns, switch special mask mode, and issue non-specific end-of-interrupt commands.

Inside the block, the fifteen usable lines are kept in one merged priority order. The eight secondary lines take the place that the primary cascade pin (pin 2) would otherwise hold. The order from highest to lowest is pin 0, pin 1, pins 8 to 15, then pins 3 to 7.

A processor-side acknowledge pulse latches the current winner and returns its 8-bit vector. If a request arrives on a line that is still requested or in service, it is parked in a one-deep pending slot rather than lost.

Each controller has its own configuration sequencer with three states:
- CFG_MASK: the idle state. Data writes load the mask.
- CFG_BASE: waiting for the vector base.
- CFG_EXTRA: discarding the remaining initialization words.

Its transitions are:
- Any command write with bit 4 set goes from any state to CFG_BASE.
- A data write in CFG_BASE goes to CFG_MASK when no extra words were announced, otherwise to CFG_EXTRA.
- The last expected data write in CFG_EXTRA returns to CFG_MASK.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, irq_out and vec_valid are 0, both mask registers read 0xFF, no request, pending or in-service bit is set, and command reads return the request register.
- R2: A command write with bit 4 set starts initialization. The next data write sets the vector base from its bits 7..3. After that, (bit0 + bit1 of the first word) further data writes are discarded, and later data writes load the mask.
- R3: A command write with bit 4 clear, bit 3 set and bit 1 set selects the command-address read: bit 0 = 1 selects in-service, bit 0 = 0 selects request. Reads are in pin order, and primary bit 2 is the OR of the eight secondary lines.
- R4: A read of the data address returns that controller's mask register.
- R5: A rising edge on irq_in sets the request bit of that line. irq_out is high in the cycle after the edge whenever a grantable request exists.
- R6: Among unmasked requests, the winner follows the order pin 0, 1, 8..15, 3..7.
- R7: A set mask bit blocks its line. Primary mask bit 2 blocks all eight secondary lines together.
- R8: A request is granted only if it ranks above every in-service line. While special mask mode is on, this rank test is skipped. Special mask mode is written by a command with bit 4 clear, bit 3 set and bit 6 set, and bit 5 gives the new value.
- R9: An int_ack pulse produces vec_valid and vec_out one cycle later. The vector is {base[7:3], pin[2:0]} of the winner's controller. The winner's in-service bit is set in the primary, and also in the secondary for pins 8..15.
- R10: If no grantable request exists at acknowledge, the vector is {primary base, 3'b111} and no state changes.
- R11: A command write with (value & 0xB8) == 0x20 clears the highest-ranked in-service bit held by that controller. A secondary line stays in service until both controllers have received this command.
- R12: An edge on a line that is requested or in service sets a one-deep pending bit. That bit becomes a request once no grant is possible and the line is idle, and it yields exactly one further interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_slave | input | 1 | 0 selects the primary controller, 1 the secondary |
| bus_addr | input | 1 | 0 command address, 1 data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_in | input | 16 | Request lines, rising-edge sampled; pin 2 has no level |
| irq_out | output | 1 | A grantable request exists |
| int_ack | input | 1 | Acknowledge pulse |
| vec_out | output | 8 | Acknowledged vector |
| vec_valid | output | 1 | vec_out is valid this cycle |

## Verification
Register writes and request edges take effect at the first clock edge that samples them. irq_out and read data are derived combinationally from that state, so they are checked at the falling edge that follows.

An acknowledge is checked the same way. Its vector and strobe become valid at the edge that samples int_ack and stay valid for exactly one cycle.

A pending request needs one more edge after the end-of-interrupt command that frees its line. The bench therefore waits one extra cycle before checking it.

All inputs are driven, and all results read, one nanosecond after a falling edge.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
    localparam int NPIN   = 16;
    localparam int NLV    = 15;
    localparam int LVW    = 4;
    localparam logic [NLV-1:0] SLAVE_LV = 15'h03FC;

    typedef enum logic [1:0] {CFG_MASK, CFG_BASE, CFG_EXTRA} cfg_state_t;

    // merged level -> pin number
    function automatic int pin_of_lv(input int l);
        if (l < 2)  return l;
        if (l < 10) return l + 6;
        return l - 7;
    endfunction

    // pin number -> merged level (pin 2 has none)
    function automatic int lv_of_pin(input int p);
        if (p < 2)  return p;
        if (p >= 8) return p - 6;
        if (p == 2) return 0;
        return p + 7;
    endfunction

    // lowest set index, NLV when empty
    function automatic logic [LVW-1:0] first_set(input logic [NLV-1:0] v);
        logic [LVW-1:0] r;
        r = LVW'(NLV);
        for (int i = NLV - 1; i >= 0; i--)
            if (v[i]) r = LVW'(i);
        return r;
    endfunction
endpackage

// File: rtl/cpic_port.sv
module cpic_port
    import cpic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       cmd_sel,
    input  logic [7:0] wdata,
    output logic [7:0] mask,
    output logic [4:0] base,
    output logic       rd_isr,
    output logic       eoi,
    output logic       smm_we,
    output logic       smm_val
);
    cfg_state_t state, state_n;
    logic [1:0] left;
    logic is_icw1, is_ocw3, data_wr;

    always_comb begin
        is_icw1 = we & cmd_sel & wdata[4];
        is_ocw3 = we & cmd_sel & ~wdata[4] & wdata[3];
        data_wr = we & ~cmd_sel;
        eoi     = we & cmd_sel & ((wdata & 8'hB8) == 8'h20);
        smm_we  = is_ocw3 & wdata[6];
        smm_val = wdata[5];
    end

    always_comb begin
        state_n = state;
        unique case (state)
            CFG_MASK:  if (is_icw1) state_n = CFG_BASE;
            CFG_BASE:  if (is_icw1) state_n = CFG_BASE;
                       else if (data_wr) state_n = (left == 2'd0) ? CFG_MASK : CFG_EXTRA;
            CFG_EXTRA: if (is_icw1) state_n = CFG_BASE;
                       else if (data_wr && left == 2'd1) state_n = CFG_MASK;
            default:   state_n = CFG_MASK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CFG_MASK;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left   <= 2'd0;
            mask   <= 8'hFF;
            base   <= 5'd0;
            rd_isr <= 1'b0;
        end else begin
            if (is_icw1)
                left <= {1'b0, wdata[0]} + {1'b0, wdata[1]};
            else if (state == CFG_EXTRA && data_wr)
                left <= left - 2'd1;
            if (state == CFG_MASK && data_wr) mask <= wdata;
            if (state == CFG_BASE && data_wr) base <= wdata[7:3];
            if (is_ocw3 && wdata[1]) rd_isr <= wdata[0];
        end
    end

    // R2
    icw1_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_icw1 |=> state == CFG_BASE);
    // R2
    base_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CFG_BASE && data_wr && left == 2'd0) |=> state == CFG_MASK);
    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == CFG_MASK && data_wr) |=> $stable(mask));
endmodule

// File: rtl/cpic_core.sv
module cpic_core
    import cpic_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NLV-1:0] lv_edge,
    input  logic [NLV-1:0] lv_mask,
    input  logic           smm,
    input  logic           eoi_m,
    input  logic           eoi_s,
    input  logic           ack,
    output logic           grant,
    output logic [LVW-1:0] win_lv,
    output logic [NLV-1:0] irr,
    output logic [NLV-1:0] isr_m,
    output logic [NLV-1:0] isr_s
);
    logic [NLV-1:0] pirr, busy, cand, rel, take, clr_m, clr_s;
    logic [LVW-1:0] hi_lv;

    always_comb begin
        busy   = irr | isr_m | isr_s;
        cand   = irr & ~(isr_m | isr_s) & ~lv_mask;
        win_lv = first_set(cand);
        hi_lv  = first_set(isr_m | isr_s);
        grant  = (|cand) && (smm || (win_lv < hi_lv));
        rel    = grant ? '0 : (pirr & ~busy);
        take   = (ack && grant) ? (NLV'(1) << win_lv) : '0;
        clr_m  = eoi_m ? (NLV'(1) << first_set(isr_m)) : '0;
        clr_s  = eoi_s ? (NLV'(1) << first_set(isr_s)) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr   <= '0;
            pirr  <= '0;
            isr_m <= '0;
            isr_s <= '0;
        end else begin
            irr   <= (irr | (lv_edge & ~busy) | rel) & ~take;
            pirr  <= (pirr | (lv_edge & busy)) & ~rel;
            isr_m <= (isr_m & ~clr_m) | take;
            isr_s <= (isr_s & ~clr_s) | (take & SLAVE_LV);
        end
    end

    // R9
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && grant) |=> |isr_m);
    // R11
    eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_m && !ack && |isr_m) |=> $countones(isr_m) == $countones($past(isr_m)) - 1);
    // R12
    pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> (($past(pirr) & ~$past(busy)) & pirr) == '0);
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
    import cpic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic            bus_slave,
    input  logic            bus_addr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic [NPIN-1:0] irq_in,
    output logic            irq_out,
    input  logic            int_ack,
    output logic [7:0]      vec_out,
    output logic            vec_valid
);
    logic [7:0] mask_a [2];
    logic [4:0] base_a [2];
    logic [1:0] rd_isr_a, eoi_a, smm_we_a, smm_val_a;
    logic smm, grant;
    logic [LVW-1:0] win_lv;
    logic [NLV-1:0] lv_prev, lv_edge, lv_mask, irr, isr_m, isr_s;
    logic [7:0] m_irr_v, m_isr_v, s_irr_v, s_isr_v;
    logic [3:0] win_pin;

    for (genvar g = 0; g < 2; g++) begin : g_port
        cpic_port u_port (
            .clk(clk), .rst_n(rst_n),
            .we(bus_we && (bus_slave == g[0])), .cmd_sel(!bus_addr),
            .wdata(bus_wdata), .mask(mask_a[g]), .base(base_a[g]),
            .rd_isr(rd_isr_a[g]), .eoi(eoi_a[g]),
            .smm_we(smm_we_a[g]), .smm_val(smm_val_a[g])
        );
    end

    for (genvar l = 0; l < NLV; l++) begin : g_lv
        localparam int P = pin_of_lv(l);
        always_ff @(posedge clk) begin
            if (!rst_n) lv_prev[l] <= 1'b0;
            else        lv_prev[l] <= irq_in[P];
        end
        assign lv_edge[l] = irq_in[P] & ~lv_prev[l];
        if (P >= 8) begin : g_s
            assign lv_mask[l] = mask_a[0][2] | mask_a[1][P-8];
        end else begin : g_m
            assign lv_mask[l] = mask_a[0][P];
        end
    end

    for (genvar p = 0; p < 8; p++) begin : g_view
        if (p == 2) begin : g_casc
            assign m_irr_v[p] = |(irr & SLAVE_LV);
            assign m_isr_v[p] = |(isr_m & SLAVE_LV);
        end else begin : g_pin
            localparam int L = lv_of_pin(p);
            assign m_irr_v[p] = irr[L];
            assign m_isr_v[p] = isr_m[L];
        end
    end
    assign s_irr_v = irr[9:2];
    assign s_isr_v = isr_s[9:2];

    always_ff @(posedge clk) begin
        if (!rst_n)           smm <= 1'b0;
        else if (smm_we_a[0]) smm <= smm_val_a[0];
        else if (smm_we_a[1]) smm <= smm_val_a[1];
    end

    cpic_core u_core (
        .clk(clk), .rst_n(rst_n), .lv_edge(lv_edge), .lv_mask(lv_mask),
        .smm(smm), .eoi_m(eoi_a[0]), .eoi_s(eoi_a[1]), .ack(int_ack),
        .grant(grant), .win_lv(win_lv), .irr(irr), .isr_m(isr_m), .isr_s(isr_s)
    );

    always_comb begin
        irq_out = grant;
        win_pin = 4'(pin_of_lv(int'(win_lv)));
        if (bus_addr)
            bus_rdata = mask_a[bus_slave];
        else if (bus_slave)
            bus_rdata = rd_isr_a[1] ? s_isr_v : s_irr_v;
        else
            bus_rdata = rd_isr_a[0] ? m_isr_v : m_irr_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out   <= 8'd0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= int_ack;
            if (int_ack) begin
                if (!grant)          vec_out <= {base_a[0], 3'b111};
                else if (win_pin[3]) vec_out <= {base_a[1], win_pin[2:0]};
                else                 vec_out <= {base_a[0], win_pin[2:0]};
            end
        end
    end

    // R9
    ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |=> vec_valid);
    // R9
    no_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |=> !vec_valid);
endmodule

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0, bus_slave = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [15:0] irq_in = 16'd0;
    logic irq_out, int_ack = 1'b0, vec_valid;
    logic [7:0] vec_out;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cascade_irq_ctrl i_cascade_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_slave(bus_slave),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out), .int_ack(int_ack),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sl, input logic a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_slave = sl; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic sl, input logic a, output logic [7:0] d);
        @(negedge clk); #1;
        bus_slave = sl; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [15:0] pins);
        @(negedge clk); #1; irq_in = pins;
        @(negedge clk); #1; irq_in = 16'd0;
    endtask

    task automatic ack(output logic [7:0] v, output logic ok);
        @(negedge clk); #1; int_ack = 1'b1;
        @(negedge clk); #1; int_ack = 1'b0;
        v = vec_out; ok = vec_valid;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 irq_out", {7'd0, irq_out}, 8'd0);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
        rd(0, 1, d); chk("R1 primary mask", d, 8'hFF);
        rd(1, 1, d); chk("R1 secondary mask", d, 8'hFF);
        rd(0, 0, d); chk("R1 primary request", d, 8'h00);
    endtask

    task automatic t_init;
        logic [7:0] d;
        wr(0, 0, 8'h11); wr(0, 1, 8'h0D); wr(0, 1, 8'h55);
        rd(0, 1, d); chk("R2 extra word discarded", d, 8'hFF);
        wr(0, 1, 8'h00);
        rd(0, 1, d); chk("R4 primary mask load", d, 8'h00);
        wr(1, 0, 8'h13); wr(1, 1, 8'h70); wr(1, 1, 8'hAA); wr(1, 1, 8'hBB);
        rd(1, 1, d); chk("R2 two extra words discarded", d, 8'hFF);
        wr(1, 1, 8'h00);
        rd(1, 1, d); chk("R4 secondary mask load", d, 8'h00);
    endtask

    task automatic t_single;
        logic [7:0] v, d; logic ok;
        pulse(16'h0008);
        chk("R5 irq_out after edge", {7'd0, irq_out}, 8'd1);
        ack(v, ok);
        chk("R9 valid", {7'd0, ok}, 8'd1);
        chk("R9 vector pin3 with base bits 7..3", v, 8'h0B);
        chk("R9 irq_out drops", {7'd0, irq_out}, 8'd0);
        wr(0, 0, 8'h0B); rd(0, 0, d); chk("R3 in-service view", d, 8'h08);
        wr(0, 0, 8'h20); rd(0, 0, d); chk("R11 EOI clears", d, 8'h00);
        wr(0, 0, 8'h0A);
    endtask

    task automatic t_priority;
        logic [7:0] v, d; logic ok;
        pulse(16'h0222);
        rd(0, 0, d); chk("R3 request view with cascade bit", d, 8'h26);
        ack(v, ok); chk("R6 pin1 first", v, 8'h09);
        chk("R8 lower blocked by in-service", {7'd0, irq_out}, 8'd0);
        wr(0, 0, 8'h20);
        chk("R8 granted after EOI", {7'd0, irq_out}, 8'd1);
        ack(v, ok); chk("R6 pin9 before pin5", v, 8'h71);
        wr(1, 0, 8'h0B); rd(1, 0, d); chk("R9 secondary in-service", d, 8'h02);
        wr(0, 0, 8'h0B); rd(0, 0, d); chk("R9 primary in-service cascade", d, 8'h04);
        wr(0, 0, 8'h20);
        chk("R11 one EOI not enough", {7'd0, irq_out}, 8'd0);
        wr(1, 0, 8'h20);
        chk("R11 second EOI releases", {7'd0, irq_out}, 8'd1);
        ack(v, ok); chk("R6 pin5 last", v, 8'h0D);
        wr(0, 0, 8'h20); wr(0, 0, 8'h0A); wr(1, 0, 8'h0A);
    endtask

    task automatic t_mask;
        logic [7:0] v; logic ok;
        wr(0, 1, 8'h04); pulse(16'h1000);
        chk("R7 cascade mask blocks pin12", {7'd0, irq_out}, 8'd0);
        wr(0, 1, 8'h00);
        chk("R7 unmask grants", {7'd0, irq_out}, 8'd1);
        ack(v, ok); chk("R9 pin12 vector", v, 8'h74);
        wr(1, 0, 8'h20); wr(0, 0, 8'h20);
        wr(1, 1, 8'h01); pulse(16'h0100);
        chk("R7 secondary bit mask", {7'd0, irq_out}, 8'd0);
        ack(v, ok); chk("R10 spurious vector", v, 8'h0F);
        chk("R10 spurious valid", {7'd0, ok}, 8'd1);
        wr(1, 1, 8'h00);
        chk("R10 request kept", {7'd0, irq_out}, 8'd1);
        ack(v, ok); chk("R9 pin8 vector", v, 8'h70);
        wr(1, 0, 8'h20); wr(0, 0, 8'h20);
    endtask

    task automatic t_smm;
        logic [7:0] v; logic ok;
        pulse(16'h0008); ack(v, ok); chk("R9 pin3", v, 8'h0B);
        pulse(16'h0040);
        chk("R8 pin6 blocked", {7'd0, irq_out}, 8'd0);
        wr(0, 0, 8'h68);
        chk("R8 special mask mode grants", {7'd0, irq_out}, 8'd1);
        ack(v, ok); chk("R8 pin6 vector", v, 8'h0E);
        wr(0, 0, 8'h48); wr(0, 0, 8'h20); wr(0, 0, 8'h20);
        chk("R11 all cleared", {7'd0, irq_out}, 8'd0);
    endtask

    task automatic t_pending;
        logic [7:0] v; logic ok;
        pulse(16'h0010); ack(v, ok); chk("R9 pin4", v, 8'h0C);
        pulse(16'h0010); pulse(16'h0010);
        chk("R12 retrigger held", {7'd0, irq_out}, 8'd0);
        wr(0, 0, 8'h20);
        @(negedge clk); #1;
        chk("R12 pending released", {7'd0, irq_out}, 8'd1);
        ack(v, ok); chk("R12 pending vector", v, 8'h0C);
        wr(0, 0, 8'h20);
        @(negedge clk); @(negedge clk); #1;
        chk("R12 one deep only", {7'd0, irq_out}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset; t_init; t_single; t_priority; t_mask; t_smm; t_pending;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule